// File: doc/BRIEF.md
# LP-to-HS Lane Entry and Exit Sequencer

This block is the transmitter-side control for one clock lane and one data lane of a serial display link that switches between low-power signalling and high-speed bursts. On a burst request it walks the clock lane out of the low-power stop state into high-speed mode. Only then does it walk the data lane through the same kind of entry. It raises a ready indication while payload bytes may be sent. After the last byte it runs the trail phases and returns both lanes to the stop state. It then holds that state for an exit time before it accepts the next request.

Every phase length is a count of byte clocks taken from a set of timing inputs. The set is copied into a shadow when a request is accepted, so writes during a burst only apply to the next one. A count of zero runs as one cycle, so no phase is ever skipped. A compliance checker multiplies each programmed count by the byte-clock period, a parameter in picoseconds. It compares the product against the lane-timing minimums, which are also parameters. A setting that is too short raises a flag and is not passed on silently.

Top module: `lphs_lane_sequencer`

## Requirements
- R1: During reset and whenever `busy` is low, both lanes show the stop state (`clk_lp` = `dat_lp` = 2'b11, where bit 1 is the positive wire and bit 0 the negative wire), both HS enables are low and `tx_ready` is low. A reset in mid-burst returns the lanes to this state at once.
- R2: A request sampled high while idle starts the burst on the next cycle. The clock lane shows LP-01 (2'b01) for LPX_CYC cycles, then LP-00 (2'b00) for the clock prepare count, then HS enabled (HS-0) for the clock zero count.
- R3: The data lane leaves the stop state only after the clock zero phase has finished, and only while `clk_hs_en` is high.
- R4: The data lane shows LP-01 for LPX_CYC cycles, then LP-00 for the data prepare count, then HS enabled without `tx_ready` for the data zero count. `tx_ready` rises after that.
- R5: A timing count of zero runs its phase for exactly one cycle. No prepare, zero, trail or exit phase is ever skipped.
- R6: `tx_ready` stays high, with both HS enables high, until a cycle in which `last_byte` is high. A burst of n bytes therefore shows n ready cycles.
- R7: After the last byte, the data lane stays in HS without ready for the data trail count. It then returns to 2'b11 while the clock lane stays in HS for the clock trail count. Both lanes then hold the stop state with `busy` high for the exit count, and after that the block is idle.
- R8: `burst_req` is sampled only while idle. A request pulse during a burst does not start a second burst.
- R9: Timing inputs are copied when a request is accepted. A change during a burst alters none of that burst's phases but sets the lengths of the next burst.
- R10: `viol` bit 0 is set when the clock prepare count times BYTE_PS is below MIN_CLK_PREP_PS. Bit 1 covers clock prepare plus zero against MIN_CLK_PZ_PS. Bit 2 covers clock trail against MIN_CLK_TRAIL_PS. Bit 3 covers data prepare plus zero against MIN_HS_PZ_PS. Bit 4 covers exit against MIN_HS_EXIT_PS. Each count is taken as at least 1. With the defaults (18519 ps per byte clock), the smallest passing values are 3, 17, 4, 10 and 6.
- R11: `timing_ok` is high exactly when no `viol` bit is set.
- R12: While a lane's HS enable is high, that lane's LP outputs are 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_req | input | 1 | Request to start a high-speed burst |
| last_byte | input | 1 | Marks the byte accepted in this ready cycle as the last one |
| cfg_clk_prep | input | CW | Clock lane prepare count |
| cfg_clk_zero | input | CW | Clock lane zero count |
| cfg_clk_trail | input | CW | Clock lane trail count |
| cfg_hs_prep | input | CW | Data lane prepare count |
| cfg_hs_zero | input | CW | Data lane zero count |
| cfg_hs_trail | input | CW | Data lane trail count |
| cfg_hs_exit | input | CW | Stop-state hold count after the burst |
| clk_lp | output | 2 | Clock lane LP drive {positive, negative} |
| clk_hs_en | output | 1 | Clock lane high-speed enable |
| dat_lp | output | 2 | Data lane LP drive {positive, negative} |
| dat_hs_en | output | 1 | Data lane high-speed enable |
| tx_ready | output | 1 | Payload byte may be presented this cycle |
| busy | output | 1 | Burst in progress, including the exit hold |
| viol | output | 5 | Per-rule timing violation flags |
| timing_ok | output | 1 | All programmed counts meet their minimums |

## Verification
The sequence is driven with five timing sets. The first is a compliant set. The second is a marginal set in which every rule is exactly one byte clock short, so that all five flags are told apart from their passing neighbours. The third is all zeros, which shows that no phase collapses to nothing. The fourth breaks only the data prepare-plus-zero rule, which isolates one flag. The fifth is a long set, which shows that the counters follow large values. Payload lengths of one to five bytes separate the ready handshake from the trail timing. Further tests change the timing set in mid-burst, pulse a request during a burst and apply reset in mid-burst, to separate shadow capture, request gating and reset from the normal walk.

// File: rtl/lphs_pkg.sv
package lphs_pkg;

   // Lane LP drive codes, {positive wire, negative wire}
   localparam logic [1:0] LP_STOP = 2'b11;
   localparam logic [1:0] LP_REQ  = 2'b01;
   localparam logic [1:0] LP_LOW  = 2'b00;

   // Positions of the timing counts inside the shadow array
   localparam int IX_CLK_PREP  = 0;
   localparam int IX_CLK_ZERO  = 1;
   localparam int IX_CLK_TRAIL = 2;
   localparam int IX_HS_PREP   = 3;
   localparam int IX_HS_ZERO   = 4;
   localparam int IX_HS_TRAIL  = 5;
   localparam int IX_HS_EXIT   = 6;
   localparam int NUM_TIMES    = 7;

   localparam int NUM_RULES    = 5;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_CK_REQ,
      PH_CK_PREP,
      PH_CK_ZERO,
      PH_DT_REQ,
      PH_DT_PREP,
      PH_DT_ZERO,
      PH_DT_SEND,
      PH_DT_TRAIL,
      PH_CK_TRAIL,
      PH_EXIT
   } phase_e;

endpackage

// File: rtl/lphs_phase_timer.sv
module lphs_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          expired
);

   logic [CW-1:0] remain_q;
   logic [CW-1:0] first_val;

   // a zero length still occupies one cycle
   always_comb begin
      if (len == '0) first_val = '0;
      else           first_val = len - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain_q <= '0;
      else if (load)            remain_q <= first_val;
      else if (remain_q != '0)  remain_q <= remain_q - CW'(1);
   end

   assign expired = (remain_q == '0);

endmodule

// File: rtl/lphs_timing_shadow.sv
module lphs_timing_shadow #(
   parameter int CW = 8,
   parameter int NT = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic [NT-1:0][CW-1:0] live,
   output logic [NT-1:0][CW-1:0] held
);

   for (genvar g = 0; g < NT; g++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        held[g] <= '0;
         else if (capture)  held[g] <= live[g];
      end
   end

endmodule

// File: rtl/lphs_min_check.sv
module lphs_min_check #(
   parameter int CW                = 8,
   parameter int BYTE_PS           = 18519,
   parameter int MIN_CLK_PREP_PS   = 38000,
   parameter int MIN_CLK_PZ_PS     = 300000,
   parameter int MIN_CLK_TRAIL_PS  = 60000,
   parameter int MIN_HS_PZ_PS      = 168200,
   parameter int MIN_HS_EXIT_PS    = 100000,
   parameter bit REG_FLAGS         = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [CW-1:0]                   c_clk_prep,
   input  logic [CW-1:0]                   c_clk_zero,
   input  logic [CW-1:0]                   c_clk_trail,
   input  logic [CW-1:0]                   c_hs_prep,
   input  logic [CW-1:0]                   c_hs_zero,
   input  logic [CW-1:0]                   c_hs_exit,
   output logic [lphs_pkg::NUM_RULES-1:0]  viol
);

   localparam int NR = lphs_pkg::NUM_RULES;
   localparam int SW = CW + 1;
   localparam int PW = SW + 32;
   localparam logic [PW-1:0] PERIOD = PW'(BYTE_PS);

   // operand slots: 0 clk prep, 1 clk zero, 2 clk trail, 3 hs prep, 4 hs zero, 5 exit
   logic [5:0][CW-1:0] slot;
   logic [5:0][SW-1:0] eff;
   logic [NR-1:0]      short_now;

   assign slot = {c_hs_exit, c_hs_zero, c_hs_prep, c_clk_trail, c_clk_zero, c_clk_prep};

   for (genvar s = 0; s < 6; s++) begin : g_eff
      assign eff[s] = (slot[s] == '0) ? SW'(1) : SW'(slot[s]);
   end

   for (genvar r = 0; r < NR; r++) begin : g_rule
      localparam int  OPA   = (r == 0) ? 0 : (r == 1) ? 0 : (r == 2) ? 2 : (r == 3) ? 3 : 5;
      localparam int  OPB   = (r == 1) ? 1 : 4;
      localparam bit  PAIR  = (r == 1) || (r == 3);
      localparam int  LIMIT = (r == 0) ? MIN_CLK_PREP_PS :
                              (r == 1) ? MIN_CLK_PZ_PS :
                              (r == 2) ? MIN_CLK_TRAIL_PS :
                              (r == 3) ? MIN_HS_PZ_PS : MIN_HS_EXIT_PS;
      localparam logic [PW-1:0] LIMIT_V = PW'(LIMIT);

      logic [SW-1:0] total;
      logic [PW-1:0] span_ps;

      if (PAIR) begin : g_pair
         assign total = eff[OPA] + eff[OPB];
      end else begin : g_single
         assign total = eff[OPA];
      end

      assign span_ps      = PW'(total) * PERIOD;
      assign short_now[r] = (span_ps < LIMIT_V);
   end

   if (REG_FLAGS) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) viol <= '0;
         else        viol <= short_now;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign viol = short_now;
   end

endmodule

// File: rtl/lphs_lane_sequencer.sv
module lphs_lane_sequencer #(
   parameter int CW                = 8,
   parameter int LPX_CYC           = 2,
   parameter int BYTE_PS           = 18519,
   parameter int MIN_CLK_PREP_PS   = 38000,
   parameter int MIN_CLK_PZ_PS     = 300000,
   parameter int MIN_CLK_TRAIL_PS  = 60000,
   parameter int MIN_HS_PZ_PS      = 168200,
   parameter int MIN_HS_EXIT_PS    = 100000,
   parameter bit REG_FLAGS         = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          burst_req,
   input  logic          last_byte,
   input  logic [CW-1:0] cfg_clk_prep,
   input  logic [CW-1:0] cfg_clk_zero,
   input  logic [CW-1:0] cfg_clk_trail,
   input  logic [CW-1:0] cfg_hs_prep,
   input  logic [CW-1:0] cfg_hs_zero,
   input  logic [CW-1:0] cfg_hs_trail,
   input  logic [CW-1:0] cfg_hs_exit,
   output logic [1:0]    clk_lp,
   output logic          clk_hs_en,
   output logic [1:0]    dat_lp,
   output logic          dat_hs_en,
   output logic          tx_ready,
   output logic          busy,
   output logic [4:0]    viol,
   output logic          timing_ok
);

   import lphs_pkg::*;

   localparam int NT = NUM_TIMES;
   localparam logic [CW-1:0] LPX_LEN = CW'(LPX_CYC);

   // elaboration-time parameter checks
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("lphs_lane_sequencer: CW must lie in 2..16");
   end
   if (LPX_CYC < 1 || LPX_CYC >= (1 << CW)) begin : g_bad_lpx
      $error("lphs_lane_sequencer: LPX_CYC must fit in CW bits and be at least 1");
   end
   if (BYTE_PS <= 0) begin : g_bad_period
      $error("lphs_lane_sequencer: BYTE_PS must be positive");
   end
   if (NUM_RULES != 5) begin : g_bad_rules
      $error("lphs_lane_sequencer: flag width does not match rule count");
   end

   logic [NT-1:0][CW-1:0] live_t;
   logic [NT-1:0][CW-1:0] held_t;
   phase_e                ph_q, ph_d;
   logic                  tmr_load;
   logic [CW-1:0]         tmr_len;
   logic                  tmr_done;
   logic                  take_req;

   always_comb begin
      live_t               = '0;
      live_t[IX_CLK_PREP]  = cfg_clk_prep;
      live_t[IX_CLK_ZERO]  = cfg_clk_zero;
      live_t[IX_CLK_TRAIL] = cfg_clk_trail;
      live_t[IX_HS_PREP]   = cfg_hs_prep;
      live_t[IX_HS_ZERO]   = cfg_hs_zero;
      live_t[IX_HS_TRAIL]  = cfg_hs_trail;
      live_t[IX_HS_EXIT]   = cfg_hs_exit;
   end

   assign take_req = (ph_q == PH_IDLE) && burst_req;

   lphs_timing_shadow #(.CW(CW), .NT(NT)) i_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (take_req),
      .live    (live_t),
      .held    (held_t)
   );

   lphs_phase_timer #(.CW(CW)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .len     (tmr_len),
      .expired (tmr_done)
   );

   lphs_min_check #(
      .CW               (CW),
      .BYTE_PS          (BYTE_PS),
      .MIN_CLK_PREP_PS  (MIN_CLK_PREP_PS),
      .MIN_CLK_PZ_PS    (MIN_CLK_PZ_PS),
      .MIN_CLK_TRAIL_PS (MIN_CLK_TRAIL_PS),
      .MIN_HS_PZ_PS     (MIN_HS_PZ_PS),
      .MIN_HS_EXIT_PS   (MIN_HS_EXIT_PS),
      .REG_FLAGS        (REG_FLAGS)
   ) i_minchk (
      .clk         (clk),
      .rst_n       (rst_n),
      .c_clk_prep  (cfg_clk_prep),
      .c_clk_zero  (cfg_clk_zero),
      .c_clk_trail (cfg_clk_trail),
      .c_hs_prep   (cfg_hs_prep),
      .c_hs_zero   (cfg_hs_zero),
      .c_hs_exit   (cfg_hs_exit),
      .viol        (viol)
   );

   assign timing_ok = (viol == '0);

   // phase walk: each timed phase loads the timer with the next phase length
   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_len  = '0;
      unique case (ph_q)
         PH_IDLE: begin
            if (burst_req) begin
               ph_d     = PH_CK_REQ;
               tmr_load = 1'b1;
               tmr_len  = LPX_LEN;
            end
         end
         PH_CK_REQ: if (tmr_done) begin
            ph_d     = PH_CK_PREP;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_CLK_PREP];
         end
         PH_CK_PREP: if (tmr_done) begin
            ph_d     = PH_CK_ZERO;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_CLK_ZERO];
         end
         PH_CK_ZERO: if (tmr_done) begin
            ph_d     = PH_DT_REQ;
            tmr_load = 1'b1;
            tmr_len  = LPX_LEN;
         end
         PH_DT_REQ: if (tmr_done) begin
            ph_d     = PH_DT_PREP;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_HS_PREP];
         end
         PH_DT_PREP: if (tmr_done) begin
            ph_d     = PH_DT_ZERO;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_HS_ZERO];
         end
         PH_DT_ZERO: if (tmr_done) begin
            ph_d = PH_DT_SEND;
         end
         PH_DT_SEND: if (last_byte) begin
            ph_d     = PH_DT_TRAIL;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_HS_TRAIL];
         end
         PH_DT_TRAIL: if (tmr_done) begin
            ph_d     = PH_CK_TRAIL;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_CLK_TRAIL];
         end
         PH_CK_TRAIL: if (tmr_done) begin
            ph_d     = PH_EXIT;
            tmr_load = 1'b1;
            tmr_len  = held_t[IX_HS_EXIT];
         end
         PH_EXIT: if (tmr_done) begin
            ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   // lane drive decode from the registered phase
   always_comb begin
      clk_lp    = LP_STOP;
      clk_hs_en = 1'b0;
      dat_lp    = LP_STOP;
      dat_hs_en = 1'b0;
      tx_ready  = 1'b0;
      busy      = (ph_q != PH_IDLE);
      unique case (ph_q)
         PH_IDLE, PH_EXIT: ;
         PH_CK_REQ:  clk_lp = LP_REQ;
         PH_CK_PREP: clk_lp = LP_LOW;
         PH_CK_ZERO, PH_CK_TRAIL: begin
            clk_lp    = LP_LOW;
            clk_hs_en = 1'b1;
         end
         PH_DT_REQ: begin
            clk_lp    = LP_LOW;
            clk_hs_en = 1'b1;
            dat_lp    = LP_REQ;
         end
         PH_DT_PREP: begin
            clk_lp    = LP_LOW;
            clk_hs_en = 1'b1;
            dat_lp    = LP_LOW;
         end
         PH_DT_ZERO, PH_DT_TRAIL: begin
            clk_lp    = LP_LOW;
            clk_hs_en = 1'b1;
            dat_lp    = LP_LOW;
            dat_hs_en = 1'b1;
         end
         PH_DT_SEND: begin
            clk_lp    = LP_LOW;
            clk_hs_en = 1'b1;
            dat_lp    = LP_LOW;
            dat_hs_en = 1'b1;
            tx_ready  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lphs_seq_chk.sv
module lphs_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       burst_req,
   input logic [1:0] clk_lp,
   input logic       clk_hs_en,
   input logic [1:0] dat_lp,
   input logic       dat_hs_en,
   input logic       tx_ready,
   input logic       busy
);

   // R1
   idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (clk_lp == 2'b11 && dat_lp == 2'b11 && !clk_hs_en && !dat_hs_en && !tx_ready));

   // R3
   clk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_lp != 2'b11 || dat_hs_en) |-> clk_hs_en);

   // R4
   hs_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_hs_en) |-> ($past(dat_lp) == 2'b00 && !$past(tx_ready)));

   // R4
   low_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dat_hs_en && dat_lp == 2'b00) |-> ($past(dat_lp) != 2'b11));

   // R6
   ready_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (dat_hs_en && clk_hs_en));

   // R7
   clk_outlasts_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_hs_en) |-> (clk_hs_en && !tx_ready));

   // R8
   start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(burst_req));

   // R12
   clk_lp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_hs_en |-> (clk_lp == 2'b00));

   // R12
   dat_lp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_hs_en |-> (dat_lp == 2'b00));

endmodule

bind lphs_lane_sequencer lphs_seq_chk i_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .burst_req (burst_req),
   .clk_lp    (clk_lp),
   .clk_hs_en (clk_hs_en),
   .dat_lp    (dat_lp),
   .dat_hs_en (dat_hs_en),
   .tx_ready  (tx_ready),
   .busy      (busy)
);

// File: tb/test_lphs_lane_sequencer.sv
`timescale 1ns/1ps
module test_lphs_lane_sequencer;

   localparam int LPX = 2;

   typedef struct packed {
      logic [7:0] cp, cz, ct, hp, hz, ht, ex, n;
      logic [4:0] vmask;
   } vec_t;

   // stimulus and expected flag mask: cp cz ct hp hz ht ex n vmask
   localparam int NV = 6;
   localparam vec_t TBL [NV] = '{
      '{8'd3,  8'd14, 8'd4, 8'd4, 8'd6,  8'd5, 8'd6,  8'd3, 5'b00000},
      '{8'd2,  8'd14, 8'd3, 8'd4, 8'd5,  8'd4, 8'd5,  8'd2, 5'b11111},
      '{8'd3,  8'd15, 8'd4, 8'd4, 8'd6,  8'd5, 8'd6,  8'd1, 5'b00000},
      '{8'd0,  8'd0,  8'd0, 8'd0, 8'd0,  8'd0, 8'd0,  8'd1, 5'b11111},
      '{8'd3,  8'd14, 8'd4, 8'd1, 8'd8,  8'd2, 8'd6,  8'd4, 5'b01000},
      '{8'd10, 8'd30, 8'd8, 8'd6, 8'd12, 8'd7, 8'd20, 8'd5, 5'b00000}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       burst_req = 1'b0;
   logic       last_byte = 1'b0;
   logic [7:0] cfg_clk_prep = '0, cfg_clk_zero = '0, cfg_clk_trail = '0;
   logic [7:0] cfg_hs_prep = '0, cfg_hs_zero = '0, cfg_hs_trail = '0, cfg_hs_exit = '0;
   logic [1:0] clk_lp, dat_lp;
   logic       clk_hs_en, dat_hs_en, tx_ready, busy, timing_ok;
   logic [4:0] viol;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lphs_lane_sequencer i_lphs_lane_sequencer (
      .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .last_byte(last_byte),
      .cfg_clk_prep(cfg_clk_prep), .cfg_clk_zero(cfg_clk_zero), .cfg_clk_trail(cfg_clk_trail),
      .cfg_hs_prep(cfg_hs_prep), .cfg_hs_zero(cfg_hs_zero), .cfg_hs_trail(cfg_hs_trail),
      .cfg_hs_exit(cfg_hs_exit),
      .clk_lp(clk_lp), .clk_hs_en(clk_hs_en), .dat_lp(dat_lp), .dat_hs_en(dat_hs_en),
      .tx_ready(tx_ready), .busy(busy), .viol(viol), .timing_ok(timing_ok)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff(input logic [7:0] x);
      return (x == 0) ? 1 : int'(x);
   endfunction

   function automatic logic [8:0] cur_code();
      return {clk_lp, clk_hs_en, dat_lp, dat_hs_en, tx_ready, busy};
   endfunction

   task automatic set_cfg(input vec_t v);
      cfg_clk_prep = v.cp;  cfg_clk_zero = v.cz;  cfg_clk_trail = v.ct;
      cfg_hs_prep  = v.hp;  cfg_hs_zero  = v.hz;  cfg_hs_trail  = v.ht;
      cfg_hs_exit  = v.ex;
   endtask

   task automatic idle_chk(input string tag);
      chk(cur_code() == 9'b11_0_11_0_0_0, tag, int'(cur_code()), 9'b11_0_11_0_0_0);
   endtask

   task automatic flag_chk(input vec_t v);
      repeat (2) @(negedge clk);
      chk(viol == v.vmask, "R10 viol mask", int'(viol), int'(v.vmask));
      chk(timing_ok == (v.vmask == 0), "R11 timing_ok", int'(timing_ok), int'(v.vmask == 0));
   endtask

   // runs one burst with v, optionally swaps the timing set or pokes a request during send
   task automatic run_burst(input vec_t v, input bit do_swap, input vec_t vs,
                            input bit poke, input string tag);
      logic [8:0] rc [16];
      int         rl [16];
      int         nr = 0;
      int         rdy = 0;
      int         bad_hs = 0;
      int         guard = 0;
      logic [8:0] exc [10];
      int         exl [10];
      string      lab [10];
      for (int i = 0; i < 16; i++) begin rc[i] = '0; rl[i] = 0; end
      exc[0] = 9'b01_0_11_0_0_1; exl[0] = LPX;         lab[0] = "R2 clk LP-01";
      exc[1] = 9'b00_0_11_0_0_1; exl[1] = eff(v.cp);   lab[1] = "R2 clk prepare";
      exc[2] = 9'b00_1_11_0_0_1; exl[2] = eff(v.cz);   lab[2] = "R2 clk zero";
      exc[3] = 9'b00_1_01_0_0_1; exl[3] = LPX;         lab[3] = "R3 R4 dat LP-01";
      exc[4] = 9'b00_1_00_0_0_1; exl[4] = eff(v.hp);   lab[4] = "R4 dat prepare";
      exc[5] = 9'b00_1_00_1_0_1; exl[5] = eff(v.hz);   lab[5] = "R4 dat zero";
      exc[6] = 9'b00_1_00_1_1_1; exl[6] = int'(v.n);   lab[6] = "R6 ready cycles";
      exc[7] = 9'b00_1_00_1_0_1; exl[7] = eff(v.ht);   lab[7] = "R7 dat trail";
      exc[8] = 9'b00_1_11_0_0_1; exl[8] = eff(v.ct);   lab[8] = "R7 clk trail";
      exc[9] = 9'b11_0_11_0_0_1; exl[9] = eff(v.ex);   lab[9] = "R7 exit hold";
      set_cfg(v);
      @(negedge clk);
      burst_req = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
      while (guard < 3000) begin
         if (!busy) break;
         if ((clk_hs_en && clk_lp != 2'b00) || (dat_hs_en && dat_lp != 2'b00)) bad_hs++;
         if (nr > 0 && cur_code() == rc[nr-1]) rl[nr-1]++;
         else if (nr < 16) begin rc[nr] = cur_code(); rl[nr] = 1; nr++; end
         if (tx_ready) begin
            rdy++;
            last_byte = (rdy == int'(v.n));
            burst_req = poke && (rdy == 1);
            if (do_swap && rdy == 1) set_cfg(vs);
         end else begin
            last_byte = 1'b0;
            burst_req = 1'b0;
         end
         @(negedge clk);
         guard++;
      end
      last_byte = 1'b0;
      burst_req = 1'b0;
      chk(nr == 10, {tag, " R7 phase count"}, nr, 10);
      for (int i = 0; i < 10; i++) begin
         chk(rc[i] == exc[i], {tag, " ", lab[i], " code"}, int'(rc[i]), int'(exc[i]));
         chk(rl[i] == exl[i], {tag, " ", lab[i], " length"}, rl[i], exl[i]);
      end
      chk(bad_hs == 0, {tag, " R12 LP low during HS"}, bad_hs, 0);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      vec_t nul;
      nul = '0;
      // R1 reset state
      repeat (3) @(negedge clk);
      idle_chk("R1 during reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idle_chk("R1 after reset");

      // table walk: flags then full burst trace
      for (int k = 0; k < NV; k++) begin
         set_cfg(TBL[k]);
         flag_chk(TBL[k]);
         run_burst(TBL[k], 1'b0, nul, 1'b0, (k == 3) ? "R5 zero-count" : "table");
         @(negedge clk);
         idle_chk("R1 idle after burst");
      end

      // R9 mid-burst change applies to the next burst only
      run_burst(TBL[0], 1'b1, TBL[5], 1'b0, "R9 swap current");
      chk(viol == TBL[5].vmask, "R10 flags follow programmed set", int'(viol), int'(TBL[5].vmask));
      run_burst(TBL[5], 1'b0, nul, 1'b0, "R9 swap next");

      // R8 request pulse during a burst is ignored
      run_burst(TBL[2], 1'b0, nul, 1'b1, "R8 poke");
      for (int c = 0; c < 6; c++) begin
         chk(busy == 1'b0, "R8 no second burst", int'(busy), 0);
         @(negedge clk);
      end

      // R1 reset in mid-burst
      set_cfg(TBL[5]);
      burst_req = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
      repeat (12) @(negedge clk);
      chk(busy == 1'b1, "R1 burst underway before reset", int'(busy), 1);
      rst_n = 1'b0;
      @(negedge clk);
      idle_chk("R1 mid-burst reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      idle_chk("R1 idle after mid-burst reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule